// File: doc/BRIEF.md
# Frame-Synchronised Stripe Pattern Generator

This block produces the raster timing for a progressive display and fills the visible area with a synthetic picture. The picture is made of horizontal stripes, vertical stripes or a checkerboard. It is drawn only inside a rectangular window, and every pixel outside that window is black. The stripe width, the colour of the first stripe and the colour increment added for each later stripe are all programmable. The default timing is a 1024x768 picture with a 65 MHz pixel clock, and every porch and sync length is a parameter.

Software programs a set of shadow registers through a Wishbone classic slave port. Those settings are copied into the working set only on the last pixel of a frame, and only when the software-controlled "settings ready" bit has passed through a two-flop synchroniser and reads 1 at that moment. A frame is therefore never drawn with a mix of old and new settings.

Each timing axis is a state machine with four states: `PH_ACTIVE`, `PH_FRONT`, `PH_SYNC` and `PH_BACK`. The transitions run `PH_ACTIVE` to `PH_FRONT`, `PH_FRONT` to `PH_SYNC`, `PH_SYNC` to `PH_BACK`, and `PH_BACK` back to `PH_ACTIVE`. Each transition is taken when the phase counter reaches the length of the current phase. The horizontal machine advances on every clock. The vertical machine advances on the last pixel of each line.

Top module: `stripe_pattern_gen`

## Requirements
- R1: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks and a frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. `hsync_n_o` is low for H_SYNC pixels starting at pixel H_ACTIVE+H_FRONT of each line. `vsync_n_o` is low for V_SYNC lines starting at line V_ACTIVE+V_FRONT. Both syncs are active low. The defaults are 1024/24/136/160 and 768/3/6/29.
- R2: `blank_o` is high outside the H_ACTIVE x V_ACTIVE area, and `rgb_o` is zero whenever `blank_o` is high.
- R3: The outputs are registered. During reset, `rgb_o` is 0, `blank_o` is 1 and both syncs are 1. The first clock edge after reset is released presents pixel (0,0), and each later edge presents the next raster position.
- R4: The register port is a Wishbone classic slave. The word index is carried on `wb_adr_i`. `wb_ack_o` rises one clock after an unacknowledged cycle-and-strobe and stays high for exactly one clock. The registers are:
  - index 0: control, with bit0 = settings ready, bit1 = enable and bits 3:2 = pattern (0 horizontal stripes, 1 vertical stripes, 2 checkerboard, 3 none).
  - index 1: x window, with first column in bits 11:0 and last column in bits 27:16, both inclusive.
  - index 2: y window, with the same layout as index 1.
  - index 3: stripe width in bits 11:0.
  - index 4: start colour, with R in 23:16, G in 15:8 and B in 7:0.
  - index 5: colour step, with the same layout as index 4.

  Reads return the written fields with all other bits zero. Indices 6 and 7 read as zero and ignore writes.
- R5: A visible pixel is black when it lies outside the window, when enable is 0, or when the pattern is 3.
- R6: With horizontal stripes, a pixel in row y inside the window has each channel equal to (start + k*step) mod 256, where k = floor((y - first row)/width).
- R7: With vertical stripes, the colour follows the same rule as R6, with k = floor((x - first column)/width).
- R8: With the checkerboard, a cell is the start colour when kx+ky is even and start+step (per channel, mod 256) when kx+ky is odd. A stripe width of 0 acts as 1 in every pattern.
- R9: Settings written while a frame is being drawn take effect no earlier than the first pixel of the next frame.
- R10: The working settings are replaced by the shadow registers only when the synchronised ready bit is 1 on the last pixel of a frame. Otherwise the previous settings are used for the whole next frame.
- R11: After reset the working settings are all zero, so the display stays black until the first replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word index |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| rgb_o | output | 24 | Pixel colour, R in bits 23:16 |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside the visible area |

## Verification
The assertions check four things on every cycle:
- Colour stays black while blanked.
- Both sync pulses fall inside the blanking interval.
- The acknowledge is single-cycle and follows a request.
- The working settings change only on the cycle after a frame-end request, and only when the synchronised ready bit was set.

The exact stripe colours, the channel wrap-around, the positions of the sync pulses, and the retention of old settings across a frame boundary with the ready bit clear can only be shown by the bench's scenarios. In those scenarios a behavioural raster model follows the bus writes and predicts every output pixel.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int COORD_W   = 12;
    localparam int CHAN_W    = 8;
    localparam int NUM_CHAN  = 3;
    localparam int RGB_W     = CHAN_W * NUM_CHAN;
    localparam int REG_ADR_W = 3;
    localparam int BUS_W     = 32;
    localparam int HI_FIELD  = 16;

    typedef enum logic [1:0] {
        PAT_LINES   = 2'd0,
        PAT_COLUMNS = 2'd1,
        PAT_CHECKER = 2'd2,
        PAT_NONE    = 2'd3
    } pattern_e;

    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_e;

    typedef struct packed {
        logic               enable;
        pattern_e           mode;
        logic [COORD_W-1:0] x_lo;
        logic [COORD_W-1:0] x_hi;
        logic [COORD_W-1:0] y_lo;
        logic [COORD_W-1:0] y_hi;
        logic [COORD_W-1:0] width;
        logic [RGB_W-1:0]   start;
        logic [RGB_W-1:0]   step;
    } pattern_cfg_t;

    localparam logic [REG_ADR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_ADR_W-1:0] REG_XWIN  = 3'd1;
    localparam logic [REG_ADR_W-1:0] REG_YWIN  = 3'd2;
    localparam logic [REG_ADR_W-1:0] REG_WIDTH = 3'd3;
    localparam logic [REG_ADR_W-1:0] REG_START = 3'd4;
    localparam logic [REG_ADR_W-1:0] REG_STEP  = 3'd5;
endpackage

// File: rtl/spg_axis.sv
module spg_axis
    import spg_pkg::*;
#(
    parameter int ACTIVE = 1024,
    parameter int FRONT  = 24,
    parameter int SYNC   = 136,
    parameter int BACK   = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    output logic [COORD_W-1:0] pos,
    output logic               active,
    output logic               sync_n,
    output logic               last
);
    phase_e             state;
    phase_e             state_nx;
    logic [COORD_W-1:0] cnt;
    logic [COORD_W-1:0] phase_len;
    logic               phase_end;

    // next-state logic
    always_comb begin
        unique case (state)
            PH_ACTIVE: phase_len = COORD_W'(ACTIVE);
            PH_FRONT:  phase_len = COORD_W'(FRONT);
            PH_SYNC:   phase_len = COORD_W'(SYNC);
            PH_BACK:   phase_len = COORD_W'(BACK);
        endcase
        phase_end = (cnt == phase_len - 1'b1);
        state_nx  = state;
        if (phase_end) begin
            unique case (state)
                PH_ACTIVE: state_nx = PH_FRONT;
                PH_FRONT:  state_nx = PH_SYNC;
                PH_SYNC:   state_nx = PH_BACK;
                PH_BACK:   state_nx = PH_ACTIVE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_ACTIVE;
            cnt   <= '0;
            pos   <= '0;
        end else if (adv) begin
            state <= state_nx;
            cnt   <= phase_end ? '0 : cnt + 1'b1;
            pos   <= last ? '0 : pos + 1'b1;
        end
    end

    // outputs
    always_comb begin
        active = (state == PH_ACTIVE);
        sync_n = (state != PH_SYNC);
        last   = (state == PH_BACK) && phase_end;
    end
endmodule

// File: rtl/spg_tracker.sv
module spg_tracker
    import spg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               last,
    input  logic [COORD_W-1:0] pos,
    input  logic [COORD_W-1:0] lo,
    input  logic [COORD_W-1:0] width,
    input  logic [RGB_W-1:0]   step,
    output logic [RGB_W-1:0]   acc,
    output logic               par
);
    logic [COORD_W-1:0] nx;
    logic [COORD_W-1:0] wlast;
    logic [COORD_W-1:0] cnt;
    logic [RGB_W-1:0]   acc_inc;

    assign nx    = last ? '0 : pos + 1'b1;
    assign wlast = (width == '0) ? '0 : width - 1'b1;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign acc_inc[c*CHAN_W +: CHAN_W] = acc[c*CHAN_W +: CHAN_W] + step[c*CHAN_W +: CHAN_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
            par <= 1'b0;
        end else if (adv) begin
            if (nx <= lo) begin
                cnt <= '0;
                acc <= '0;
                par <= 1'b0;
            end else if (cnt == wlast) begin
                cnt <= '0;
                acc <= acc_inc;
                par <= ~par;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spg_regs.sv
module spg_regs
    import spg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_cyc,
    input  logic                 wb_stb,
    input  logic                 wb_we,
    input  logic [REG_ADR_W-1:0] wb_adr,
    input  logic [BUS_W-1:0]     wb_dat_i,
    output logic [BUS_W-1:0]     wb_dat_o,
    output logic                 wb_ack,
    input  logic                 frame_req,
    output pattern_cfg_t         act_cfg,
    output logic                 valid_sync
);
    localparam int PAD = HI_FIELD - COORD_W;

    pattern_cfg_t   shadow;
    logic           shadow_valid;
    logic           sync_s1;
    logic           req;
    logic [BUS_W-1:0] rd;

    assign req = wb_cyc & wb_stb & ~wb_ack;

    always_comb begin
        case (wb_adr)
            REG_CTRL:  rd = BUS_W'({shadow.mode, shadow.enable, shadow_valid});
            REG_XWIN:  rd = BUS_W'({shadow.x_hi, {PAD{1'b0}}, shadow.x_lo});
            REG_YWIN:  rd = BUS_W'({shadow.y_hi, {PAD{1'b0}}, shadow.y_lo});
            REG_WIDTH: rd = BUS_W'(shadow.width);
            REG_START: rd = BUS_W'(shadow.start);
            REG_STEP:  rd = BUS_W'(shadow.step);
            default:   rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow       <= '0;
            shadow_valid <= 1'b0;
            wb_ack       <= 1'b0;
            wb_dat_o     <= '0;
        end else begin
            wb_ack <= req;
            if (req && !wb_we) begin
                wb_dat_o <= rd;
            end
            if (req && wb_we) begin
                case (wb_adr)
                    REG_CTRL: begin
                        shadow_valid  <= wb_dat_i[0];
                        shadow.enable <= wb_dat_i[1];
                        shadow.mode   <= pattern_e'(wb_dat_i[3:2]);
                    end
                    REG_XWIN: begin
                        shadow.x_lo <= wb_dat_i[COORD_W-1:0];
                        shadow.x_hi <= wb_dat_i[HI_FIELD +: COORD_W];
                    end
                    REG_YWIN: begin
                        shadow.y_lo <= wb_dat_i[COORD_W-1:0];
                        shadow.y_hi <= wb_dat_i[HI_FIELD +: COORD_W];
                    end
                    REG_WIDTH: shadow.width <= wb_dat_i[COORD_W-1:0];
                    REG_START: shadow.start <= wb_dat_i[RGB_W-1:0];
                    REG_STEP:  shadow.step  <= wb_dat_i[RGB_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // ready-bit synchroniser and frame-boundary commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_s1    <= 1'b0;
            valid_sync <= 1'b0;
            act_cfg    <= '0;
        end else begin
            sync_s1    <= shadow_valid;
            valid_sync <= sync_s1;
            if (frame_req && valid_sync) begin
                act_cfg <= shadow;
            end
        end
    end
endmodule

// File: rtl/spg_render.sv
module spg_render
    import spg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_act,
    input  logic               v_act,
    input  logic               hs_n,
    input  logic               vs_n,
    input  logic [COORD_W-1:0] hpos,
    input  logic [COORD_W-1:0] vpos,
    input  pattern_cfg_t       cfg,
    input  logic [RGB_W-1:0]   hacc,
    input  logic               hpar,
    input  logic [RGB_W-1:0]   vacc,
    input  logic               vpar,
    output logic [RGB_W-1:0]   rgb_o,
    output logic               hsync_n_o,
    output logic               vsync_n_o,
    output logic               blank_o
);
    logic [RGB_W-1:0] line_col;
    logic [RGB_W-1:0] col_col;
    logic [RGB_W-1:0] alt_col;
    logic [RGB_W-1:0] pix;
    logic             visible;
    logic             in_roi;
    logic             draw;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_mix
        assign line_col[c*CHAN_W +: CHAN_W] = cfg.start[c*CHAN_W +: CHAN_W] + vacc[c*CHAN_W +: CHAN_W];
        assign col_col[c*CHAN_W +: CHAN_W]  = cfg.start[c*CHAN_W +: CHAN_W] + hacc[c*CHAN_W +: CHAN_W];
        assign alt_col[c*CHAN_W +: CHAN_W]  = cfg.start[c*CHAN_W +: CHAN_W] + cfg.step[c*CHAN_W +: CHAN_W];
    end

    always_comb begin
        unique case (cfg.mode)
            PAT_LINES:   pix = line_col;
            PAT_COLUMNS: pix = col_col;
            PAT_CHECKER: pix = (hpar ^ vpar) ? alt_col : cfg.start;
            PAT_NONE:    pix = '0;
        endcase
        visible = h_act & v_act;
        in_roi  = (hpos >= cfg.x_lo) && (hpos <= cfg.x_hi) &&
                  (vpos >= cfg.y_lo) && (vpos <= cfg.y_hi);
        draw    = visible & cfg.enable & in_roi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_o     <= '0;
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
            blank_o   <= 1'b1;
        end else begin
            rgb_o     <= draw ? pix : '0;
            hsync_n_o <= hs_n;
            vsync_n_o <= vs_n;
            blank_o   <= ~visible;
        end
    end
endmodule

// File: rtl/stripe_pattern_gen.sv
module stripe_pattern_gen
    import spg_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int H_FRONT  = 24,
    parameter int H_SYNC   = 136,
    parameter int H_BACK   = 160,
    parameter int V_ACTIVE = 768,
    parameter int V_FRONT  = 3,
    parameter int V_SYNC   = 6,
    parameter int V_BACK   = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_cyc_i,
    input  logic                 wb_stb_i,
    input  logic                 wb_we_i,
    input  logic [REG_ADR_W-1:0] wb_adr_i,
    input  logic [BUS_W-1:0]     wb_dat_i,
    output logic [BUS_W-1:0]     wb_dat_o,
    output logic                 wb_ack_o,
    output logic [RGB_W-1:0]     rgb_o,
    output logic                 hsync_n_o,
    output logic                 vsync_n_o,
    output logic                 blank_o
);
    logic [COORD_W-1:0] hpos, vpos;
    logic               h_act, v_act, hs_n, vs_n, hlast, vlast;
    logic               frame_req;
    logic               valid_sync;
    pattern_cfg_t       act_cfg;
    logic [RGB_W-1:0]   hacc, vacc;
    logic               hpar, vpar;

    assign frame_req = hlast & vlast;

    spg_axis #(.ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK)) u_haxis (
        .clk(clk), .rst_n(rst_n), .adv(1'b1),
        .pos(hpos), .active(h_act), .sync_n(hs_n), .last(hlast)
    );

    spg_axis #(.ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK)) u_vaxis (
        .clk(clk), .rst_n(rst_n), .adv(hlast),
        .pos(vpos), .active(v_act), .sync_n(vs_n), .last(vlast)
    );

    spg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc(wb_cyc_i), .wb_stb(wb_stb_i), .wb_we(wb_we_i),
        .wb_adr(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack_o),
        .frame_req(frame_req), .act_cfg(act_cfg), .valid_sync(valid_sync)
    );

    spg_tracker u_htrk (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .last(hlast), .pos(hpos),
        .lo(act_cfg.x_lo), .width(act_cfg.width), .step(act_cfg.step),
        .acc(hacc), .par(hpar)
    );

    spg_tracker u_vtrk (
        .clk(clk), .rst_n(rst_n), .adv(hlast), .last(vlast), .pos(vpos),
        .lo(act_cfg.y_lo), .width(act_cfg.width), .step(act_cfg.step),
        .acc(vacc), .par(vpar)
    );

    spg_render u_render (
        .clk(clk), .rst_n(rst_n),
        .h_act(h_act), .v_act(v_act), .hs_n(hs_n), .vs_n(vs_n),
        .hpos(hpos), .vpos(vpos), .cfg(act_cfg),
        .hacc(hacc), .hpar(hpar), .vacc(vacc), .vpar(vpar),
        .rgb_o(rgb_o), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .blank_o(blank_o)
    );
endmodule

// File: rtl/spg_checker.sv
module spg_checker
    import spg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_ack,
    input logic             blank,
    input logic [RGB_W-1:0] rgb,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic             frame_req,
    input logic             valid_sync,
    input pattern_cfg_t     act_cfg
);
    assert_black_in_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (rgb == '0));

    assert_hsync_in_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> blank);

    assert_vsync_in_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> blank);

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_cyc && wb_stb));

    assert_commit_at_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg != $past(act_cfg)) |-> $past(frame_req));

    assert_commit_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg != $past(act_cfg)) |-> $past(valid_sync));
endmodule

bind stripe_pattern_gen spg_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc(wb_cyc_i), .wb_stb(wb_stb_i), .wb_ack(wb_ack_o),
    .blank(blank_o), .rgb(rgb_o), .hsync_n(hsync_n_o), .vsync_n(vsync_n_o),
    .frame_req(frame_req), .valid_sync(valid_sync), .act_cfg(act_cfg)
);

// File: tb/stripe_pattern_gen_test.sv
module stripe_pattern_gen_test;
    localparam int HA = 16, HF = 2, HS = 3, HB = 3;
    localparam int VA = 12, VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FRAME = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc, stb, we;
    logic [2:0]  adr;
    logic [31:0] dat_w;
    logic [31:0] dat_r;
    logic        ack;
    logic [23:0] rgb;
    logic        hs_n, vs_n, blank;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    bit    m_ready = 0;
    string cur_tag = "R3";

    always #5 clk = ~clk;

    stripe_pattern_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_dat_i(dat_w), .wb_dat_o(dat_r), .wb_ack_o(ack),
        .rgb_o(rgb), .hsync_n_o(hs_n), .vsync_n_o(vs_n), .blank_o(blank)
    );

    // ---------------- behavioural reference model ----------------
    int          m_x, m_y;
    logic [31:0] sh [6];
    logic [31:0] ac [6];
    bit          vs1, vs2, m_ack;
    logic [23:0] e_rgb;
    logic        e_blank, e_hs, e_vs;

    function automatic logic [31:0] field_mask(int a);
        case (a)
            0:       return 32'h0000_000F;
            1, 2:    return 32'h0FFF_0FFF;
            3:       return 32'h0000_0FFF;
            default: return 32'h00FF_FFFF;
        endcase
    endfunction

    function automatic logic [23:0] exp_rgb(int x, int y);
        int xlo, xhi, ylo, yhi, w, kx, ky, k;
        logic [23:0] res;
        xlo = int'(ac[1][11:0]);  xhi = int'(ac[1][27:16]);
        ylo = int'(ac[2][11:0]);  yhi = int'(ac[2][27:16]);
        w   = int'(ac[3][11:0]);
        if (w == 0) w = 1;
        if (!ac[0][1] || ac[0][3:2] == 2'd3) return 24'h0;
        if (x < xlo || x > xhi || y < ylo || y > yhi) return 24'h0;
        kx = (x - xlo) / w;
        ky = (y - ylo) / w;
        case (ac[0][3:2])
            2'd0:    k = ky;
            2'd1:    k = kx;
            default: k = (kx + ky) % 2;
        endcase
        for (int c = 0; c < 3; c++) begin
            res[c*8 +: 8] = 8'((int'(ac[4][c*8 +: 8]) + k * int'(ac[5][c*8 +: 8])) % 256);
        end
        return res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = 0; m_y = 0; vs1 = 0; vs2 = 0; m_ack = 0;
            for (int i = 0; i < 6; i++) begin sh[i] = '0; ac[i] = '0; end
            e_rgb = '0; e_blank = 1; e_hs = 1; e_vs = 1;
        end else begin
            bit req;
            e_blank = !(m_x < HA && m_y < VA);
            e_hs    = !(m_x >= HA + HF && m_x < HA + HF + HS);
            e_vs    = !(m_y >= VA + VF && m_y < VA + VF + VS);
            e_rgb   = e_blank ? 24'h0 : exp_rgb(m_x, m_y);
            if (m_x == HT - 1 && m_y == VT - 1 && vs2) begin
                for (int i = 0; i < 6; i++) ac[i] = sh[i];
            end
            if (m_x == HT - 1) begin
                m_x = 0;
                m_y = (m_y == VT - 1) ? 0 : m_y + 1;
            end else begin
                m_x = m_x + 1;
            end
            vs2 = vs1;
            vs1 = sh[0][0];
            req = cyc && stb && !m_ack;
            if (req && we && adr < 3'd6) sh[adr] = dat_w & field_mask(int'(adr));
            m_ack = req;
        end
        m_ready = 1;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (m_ready && !done) begin
            compared += 4;
            if (rgb !== e_rgb) begin
                mismatched++;
                $display("FAIL %s rgb at (%0d,%0d): actual %h expected %h", cur_tag, m_x, m_y, rgb, e_rgb);
            end
            if (blank !== e_blank) begin
                mismatched++;
                $display("FAIL R2 blank: actual %b expected %b", blank, e_blank);
            end
            if (hs_n !== e_hs) begin
                mismatched++;
                $display("FAIL R1 hsync_n: actual %b expected %b", hs_n, e_hs);
            end
            if (vs_n !== e_vs) begin
                mismatched++;
                $display("FAIL R1 vsync_n: actual %b expected %b", vs_n, e_vs);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = a; dat_w = d;
        do @(negedge clk); while (!ack);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 0; adr = a;
        do @(negedge clk); while (!ack);
        d = dat_r;
        cyc = 0; stb = 0;
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s readback: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_row(input int y);
        @(negedge clk);
        while (!(m_y == y && m_x == 0)) @(negedge clk);
    endtask

    task automatic frames(input int n);
        repeat (n * FRAME) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] rd;
        rst_n = 0; cyc = 0; stb = 0; we = 0; adr = '0; dat_w = '0;
        cur_tag = "R3";
        repeat (4) @(negedge clk);
        rst_n = 1;
        cur_tag = "R11";
        frames(1);

        cur_tag = "R4";
        wb_write(3'd1, 32'hF00C_F003);
        wb_write(3'd2, 32'h0009_0002);
        wb_write(3'd3, 32'd3);
        wb_write(3'd4, 32'h0010_F0FE);
        wb_write(3'd5, 32'h0020_0803);
        wb_write(3'd0, 32'h2);
        wb_write(3'd6, 32'hFFFF_FFFF);
        wb_read(3'd1, rd); check_word("R4", rd, 32'h000C_0003);
        wb_read(3'd3, rd); check_word("R4", rd, 32'h0000_0003);
        wb_read(3'd0, rd); check_word("R4", rd, 32'h0000_0002);
        wb_read(3'd5, rd); check_word("R4", rd, 32'h0020_0803);
        wb_read(3'd6, rd); check_word("R4", rd, 32'h0000_0000);

        cur_tag = "R10";
        frames(1);
        wb_write(3'd0, 32'h3);
        cur_tag = "R6";
        frames(2);

        wait_row(4);
        wb_write(3'd0, 32'h6);
        cur_tag = "R10";
        frames(1);
        wb_write(3'd0, 32'h7);
        cur_tag = "R7";
        frames(2);

        wait_row(5);
        cur_tag = "R9";
        wb_write(3'd4, 32'h0000_00FF);
        frames(2);

        wb_write(3'd3, 32'd0);
        wb_write(3'd0, 32'hB);
        cur_tag = "R8";
        frames(2);
        wb_write(3'd3, 32'd2);
        frames(2);

        cur_tag = "R5";
        wb_write(3'd0, 32'hF);
        frames(2);
        wb_write(3'd0, 32'h9);
        frames(2);
        wb_write(3'd1, 32'h0002_0008);
        wb_write(3'd0, 32'hB);
        frames(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule